// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block raises a doorbell interrupt between the two ports of a shared word memory. The two highest word addresses are fixed mailboxes, one owned by each port. The all-ones address belongs to port 1, and the address one below it belongs to port 0. When one port writes into the mailbox of the other port, the owner's interrupt is asserted. When the owner reads its own mailbox, the interrupt is retired.

The block observes each port's enable, write strobe, output enable, address and the contention busy flag that the arbiter drives toward that port. A port that sees busy can neither raise the other side's flag nor retire its own flag. The message word itself lives in the memory array, and the arbitration that produces busy is outside this block. All strobes are sampled on the rising clock edge. The flag register updates on that same edge, and the active-low outputs reflect the new state one cycle after the access is presented.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both `irq0_n_o` and `irq1_n_o` are 1 (inactive).
- R2: A port-0 write (en=1, we=1) to address 14'h3FFF, with `p0_busy_i`=0, drives `irq1_n_o` to 0 after the sampling edge.
- R3: A port-1 write (en=1, we=1) to address 14'h3FFE, with `p1_busy_i`=0, drives `irq0_n_o` to 0 after the sampling edge.
- R4: A read (en=1, oe=1, we=0) by the owning port of its own mailbox (port 0 at 14'h3FFE, port 1 at 14'h3FFF), with that port's busy=0, returns its interrupt output to 1. An access with we=1 is a write and never clears.
- R5: A port reading the other port's mailbox leaves both interrupts unchanged.
- R6: While a port's busy input is 1, its write to the other port's mailbox does not set the other port's interrupt.
- R7: While a port's busy input is 1, its read of its own mailbox does not clear its interrupt.
- R8: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R9: Accesses with en=0, writes to a port's own mailbox, and accesses to any other address have no effect on either interrupt.
- R10: With no qualifying access, both interrupt outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p0_en_i | input | 1 | Port 0 access enable |
| p0_we_i | input | 1 | Port 0 write strobe |
| p0_oe_i | input | 1 | Port 0 output enable (read) |
| p0_addr_i | input | 14 | Port 0 word address |
| p0_busy_i | input | 1 | Contention busy toward port 0 |
| p1_en_i | input | 1 | Port 1 access enable |
| p1_we_i | input | 1 | Port 1 write strobe |
| p1_oe_i | input | 1 | Port 1 output enable (read) |
| p1_addr_i | input | 14 | Port 1 word address |
| p1_busy_i | input | 1 | Contention busy toward port 1 |
| irq0_n_o | output | 1 | Port 0 interrupt, active low |
| irq1_n_o | output | 1 | Port 1 interrupt, active low |

## Verification
The bench targets the reads that must not clear: a port reading its peer's mailbox, a read with busy active, and a write to a port's own mailbox. A design that decodes the address without the port identity or drops the busy gate would release the flag too early in these cases. It also drives a set and a clear at the same flag in one cycle. A design with clear priority would leave the flag inactive and lose a doorbell. Addresses adjacent to the mailboxes, accesses with the enable low, and a long mixed random stretch checked against a reference model show whether the address decode is too wide or the strobe qualification is missing.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned NPORTS = 2;

  typedef struct packed {
    logic en;
    logic we;
    logic oe;
    logic busy;
  } port_ctl_t;

  typedef struct packed {
    logic ring_peer;  // qualified write into peer mailbox
    logic ack_own;    // qualified read of own mailbox
  } port_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_ADDR = '1,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '0
) (
  input  port_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output port_evt_t         evt_o
);
  logic wr_acc, rd_acc, hit_own, hit_peer;

  assign wr_acc   = ctl_i.en & ctl_i.we;
  assign rd_acc   = ctl_i.en & ctl_i.oe & ~ctl_i.we;
  assign hit_own  = (addr_i == OWN_ADDR);
  assign hit_peer = (addr_i == PEER_ADDR);

  // busy toward this port suppresses both its doorbell and its acknowledge
  assign evt_o.ring_peer = wr_acc & hit_peer & ~ctl_i.busy;
  assign evt_o.ack_own   = rd_acc & hit_own  & ~ctl_i.busy;
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;  // set has priority
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign irq_n_o = ~pend_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !irq_n_o);
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> irq_n_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p0_en_i,
  input  logic              p0_we_i,
  input  logic              p0_oe_i,
  input  logic [ADDR_W-1:0] p0_addr_i,
  input  logic              p0_busy_i,
  input  logic              p1_en_i,
  input  logic              p1_we_i,
  input  logic              p1_oe_i,
  input  logic [ADDR_W-1:0] p1_addr_i,
  input  logic              p1_busy_i,
  output logic              irq0_n_o,
  output logic              irq1_n_o
);
  localparam logic [ADDR_W-1:0] MBX_P1 = '1;
  localparam logic [ADDR_W-1:0] MBX_P0 = {{(ADDR_W-1){1'b1}}, 1'b0};

  port_ctl_t         ctl  [NPORTS];
  logic [ADDR_W-1:0] addr [NPORTS];
  port_evt_t         evt  [NPORTS];
  logic [NPORTS-1:0] irq_n;

  assign ctl[0]  = '{en: p0_en_i, we: p0_we_i, oe: p0_oe_i, busy: p0_busy_i};
  assign ctl[1]  = '{en: p1_en_i, we: p1_we_i, oe: p1_oe_i, busy: p1_busy_i};
  assign addr[0] = p0_addr_i;
  assign addr[1] = p1_addr_i;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (g == 0) ? MBX_P0 : MBX_P1;
    localparam logic [ADDR_W-1:0] PEER = (g == 0) ? MBX_P1 : MBX_P0;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) u_dec (
      .ctl_i (ctl[g]),
      .addr_i(addr[g]),
      .evt_o (evt[g])
    );

    // flag g is rung by the opposite port, acknowledged by port g
    mbx_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[NPORTS-1-g].ring_peer),
      .clr_i  (evt[g].ack_own),
      .irq_n_o(irq_n[g])
    );
  end

  assign irq0_n_o = irq_n[0];
  assign irq1_n_o = irq_n[1];

  assert_ring_p1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_en_i && p0_we_i && p0_addr_i == MBX_P1 && !p0_busy_i) |=> !irq1_n_o);
  assert_ring_p0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_en_i && p1_we_i && p1_addr_i == MBX_P0 && !p1_busy_i) |=> !irq0_n_o);
  assert_busy_no_ring_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_busy_i && irq1_n_o && !(p1_en_i && p1_oe_i && !p1_we_i && p1_addr_i == MBX_P1))
    |=> irq1_n_o);
  assert_busy_no_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_busy_i && !irq1_n_o) |=> !irq1_n_o);
  assert_peer_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq0_n_o && !(p0_en_i && p0_oe_i && !p0_we_i && p0_addr_i == MBX_P0)) |=> !irq0_n_o);
endmodule

// File: tb/mbx_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_test;
  localparam int AW = 14;
  localparam logic [AW-1:0] A_P1 = 14'h3FFF;
  localparam logic [AW-1:0] A_P0 = 14'h3FFE;

  typedef struct packed {
    logic en; logic we; logic oe; logic busy; logic [AW-1:0] addr;
  } stim_t;

  typedef struct {
    logic e0_n; logic e1_n; string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  stim_t s0, s1;
  logic irq0_n, irq1_n;
  int checks = 0, fails = 0;
  logic m0 = 1'b0, m1 = 1'b0;  // model: 1 = pending
  exp_t q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .p0_en_i(s0.en), .p0_we_i(s0.we), .p0_oe_i(s0.oe), .p0_addr_i(s0.addr), .p0_busy_i(s0.busy),
    .p1_en_i(s1.en), .p1_we_i(s1.we), .p1_oe_i(s1.oe), .p1_addr_i(s1.addr), .p1_busy_i(s1.busy),
    .irq0_n_o(irq0_n), .irq1_n_o(irq1_n)
  );

  function automatic stim_t idle();
    return '{en:1'b0, we:1'b0, oe:1'b0, busy:1'b0, addr:'0};
  endfunction
  function automatic stim_t wr(logic [AW-1:0] a, logic b);
    return '{en:1'b1, we:1'b1, oe:1'b0, busy:b, addr:a};
  endfunction
  function automatic stim_t rd(logic [AW-1:0] a, logic b);
    return '{en:1'b1, we:1'b0, oe:1'b1, busy:b, addr:a};
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push expected outputs after the edge
  task automatic step(stim_t a, stim_t b, string tag);
    logic set0, set1, clr0, clr1;
    exp_t e;
    @(posedge clk); #2;
    s0 = a; s1 = b;
    set1 = a.en && a.we && a.addr == A_P1 && !a.busy;
    set0 = b.en && b.we && b.addr == A_P0 && !b.busy;
    clr0 = a.en && a.oe && !a.we && a.addr == A_P0 && !a.busy;
    clr1 = b.en && b.oe && !b.we && b.addr == A_P1 && !b.busy;
    if (set0) m0 = 1'b1; else if (clr0) m0 = 1'b0;
    if (set1) m1 = 1'b1; else if (clr1) m1 = 1'b0;
    e.e0_n = ~m0; e.e1_n = ~m1; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after the sampling edge
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      @(posedge clk); #3;
      e = q.pop_front();
      check(irq0_n, e.e0_n, {e.tag, " irq0"});
      check(irq1_n, e.e1_n, {e.tag, " irq1"});
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    s0 = idle(); s1 = idle();
    #20;
    check(irq0_n, 1'b1, "R1 reset irq0");
    check(irq1_n, 1'b1, "R1 reset irq1");
    rst_n = 1'b1;
    step(idle(), idle(), "R10 idle");
    step(wr(A_P1, 1'b0), idle(), "R2 ring p1");
    step(wr(A_P0, 1'b0), idle(), "R9 own-mailbox write p0");
    step(rd(A_P1, 1'b0), idle(), "R5 p0 reads peer");
    step(idle(), rd(A_P1, 1'b1), "R7 busy ack p1");
    step(idle(), '{en:1'b1, we:1'b1, oe:1'b1, busy:1'b0, addr:A_P1}, "R4 we=1 not a read");
    step(idle(), '{en:1'b0, we:1'b0, oe:1'b1, busy:1'b0, addr:A_P1}, "R9 en low");
    step(idle(), rd(14'h3FFD, 1'b0), "R9 other address");
    step(idle(), rd(A_P1, 1'b0), "R4 ack p1");
    step(idle(), wr(A_P0, 1'b1), "R6 busy ring p0");
    step(wr(A_P1, 1'b1), idle(), "R6 busy ring p1");
    step(idle(), wr(A_P0, 1'b0), "R3 ring p0");
    step(idle(), idle(), "R10 hold");
    step(rd(A_P0, 1'b1), idle(), "R7 busy ack p0");
    step(idle(), rd(A_P0, 1'b0), "R5 p1 reads peer");
    step(rd(A_P0, 1'b0), wr(A_P0, 1'b0), "R8 set beats clear");
    step(rd(A_P0, 1'b0), idle(), "R4 ack p0");
    step(wr(14'h3FFD, 1'b0), wr(14'h0000, 1'b0), "R9 near addresses");
    step(wr(A_P1, 1'b0), wr(A_P0, 1'b0), "R2 R3 both ring");
    step(rd(A_P0, 1'b0), rd(A_P1, 1'b0), "R4 both ack");
    for (int i = 0; i < 400; i++) begin
      stim_t a, b;
      logic [AW-1:0] pick [4];
      pick[0] = A_P1; pick[1] = A_P0; pick[2] = 14'h3FFD; pick[3] = 14'h1FFF;
      a = '{en:1'($urandom), we:1'($urandom), oe:1'($urandom),
            busy:($urandom_range(0, 3) == 0), addr:pick[$urandom_range(0, 3)]};
      b = '{en:1'($urandom), we:1'($urandom), oe:1'($urandom),
            busy:($urandom_range(0, 3) == 0), addr:pick[$urandom_range(0, 3)]};
      step(a, b, "R2-mix random");
    end
    step(idle(), idle(), "R10 drain");
    wait (q.size() == 0);
    @(posedge clk); #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule